// File: doc/BRIEF.md
# CCD Frame Readout and Region-of-Interest Sequencer

This block walks a CCD array row by row and decides, for every step of the readout, which waveform table an external table player must run. A row begins with one vertical charge transfer. Each column position then gets exactly one horizontal table. A column inside the selected rectangle gets a slow table that shifts the charge and converts it. Every other column gets a fast table that shifts the charge and throws it away. Rows outside the rectangle are flushed entirely with fast tables. The result is a short frame time when the region of interest is small, while pixels inside the region keep their full low-noise conversion time.

The sequencer hands out one table at a time. It pulses `tbl_go` together with `tbl_sel` and waits for `tbl_fin` before it chooses the next table. The window origin, the window size and the two transfer directions are sampled when `kick` is accepted, so the inputs may change during the frame. After each slow table finishes, the block gives a one-cycle pixel strobe carrying coordinates relative to the window corner. `cancel` ends a frame early but cleanly.

The controller is built around four states:
- `S_IDLE`: waiting for `kick`.
- `S_ISSUE`: the one cycle in which a table request is driven.
- `S_WAIT`: waiting for the table player to report completion.
- `S_END`: the one cycle in which frame completion is reported.

The transitions are:
- idle→issue on an accepted `kick`.
- issue→wait unconditionally.
- wait→issue on completion of a table that is not the last one.
- wait→end on completion of the last table, or on completion of any table once a cancel is pending.
- end→idle unconditionally.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset, `busy`, `tbl_go`, `pix_stb`, `frame_end` and `frame_cut` are all 0.
- R2: `kick` is accepted only while idle. The window and direction inputs are captured at that moment, and later changes to them do not affect the frame. A `kick` while busy is ignored.
- R3: Each table request is a single-cycle `tbl_go` pulse. No new request appears until `tbl_fin` has been seen for the previous one, and the next request comes in the cycle right after that `tbl_fin`.
- R4: A frame is ROWS rows. Each row is one vertical table followed by COLS horizontal tables, which makes ROWS*(COLS+1) tables in total.
- R5: The `tbl_sel` encoding is as follows:
  - A vertical table is 0 + `vdir`, where `vdir` 0 means up and 1 means down.
  - A fast horizontal table is 2 + `hdir`, where `hdir` 0 means left and 1 means right.
  - A slow horizontal table is 4 + `hdir`.
- R6: A horizontal table is slow exactly when its row lies in [row_lo, row_hi) and its column lies in [col_lo, col_hi). All other horizontal tables are fast.
- R7: On each axis, lo = min(origin, EXTENT) and hi = min(origin + size, EXTENT). A window that runs past the array edge is therefore clipped.
- R8: If either size is zero, the frame runs as a full fast flush with no slow tables and no pixel strobes.
- R9: `pix_stb` is high for one cycle, in the cycle after each slow table's `tbl_fin`. It carries `pix_row` = row − row_lo and `pix_col` = col − col_lo.
- R10: `frame_end` is high for one cycle, in the cycle after the last table's `tbl_fin`, with `frame_cut` = 0. `busy` is 0 in the following cycle.
- R11: A `cancel` while busy lets the table in progress finish. After that table's `tbl_fin`, no further table is issued, and `frame_end` and `frame_cut` are both high for one cycle. A `cancel` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start a frame (accepted while idle) |
| cancel | input | 1 | Abort the frame after the current table |
| roi_row0 | input | W | Window first row |
| roi_col0 | input | W | Window first column |
| roi_nrows | input | W | Window height |
| roi_ncols | input | W | Window width |
| hdir | input | 1 | Horizontal direction, 0 left / 1 right |
| vdir | input | 1 | Vertical direction, 0 up / 1 down |
| tbl_go | output | 1 | Table request pulse |
| tbl_sel | output | 3 | Table index, valid with `tbl_go` |
| tbl_fin | input | 1 | Table completed |
| busy | output | 1 | Frame in progress |
| pix_stb | output | 1 | Converted pixel strobe |
| pix_row | output | W | Window-relative row |
| pix_col | output | W | Window-relative column |
| frame_end | output | 1 | Frame finished pulse |
| frame_cut | output | 1 | Frame ended by cancel (with `frame_end`) |

W is $clog2(max(ROWS,COLS)+1).

## Verification
A wrong row or column position shows up at the table-index port quickly. It appears no later than the next table request as a wrong table class or direction, or as a slow table outside the window. A bad window bound appears within one row as misplaced slow tables and wrong relative pixel coordinates. Errors in the state sequence show up at the handshake edge within one cycle of a `tbl_fin`, as one of three symptoms:
- a missing or duplicated request;
- an early or missing `frame_end`;
- a wrong `frame_cut` flag.

// File: rtl/ccd_rd_pkg.sv
package ccd_rd_pkg;

    // table class occupies tbl_sel[2:1]; direction bit is tbl_sel[0]
    localparam logic [1:0] CLS_VERT = 2'd0;
    localparam logic [1:0] CLS_FAST = 2'd1;
    localparam logic [1:0] CLS_SLOW = 2'd2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_END
    } seq_state_t;

    function automatic logic [2:0] make_sel(input logic [1:0] cls, input logic dir);
        return {cls, dir};
    endfunction

endpackage

// File: rtl/ccd_win_clip.sv
module ccd_win_clip #(
    parameter int EXTENT = 1024,
    parameter int W      = 11
) (
    input  logic [W-1:0] origin,
    input  logic [W-1:0] size,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    localparam logic [W:0]   EXT_WIDE = (W+1)'(EXTENT);
    localparam logic [W-1:0] EXT_N    = W'(EXTENT);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, origin} + {1'b0, size};
        lo  = (origin > EXT_N) ? EXT_N : origin;
        hi  = (sum > EXT_WIDE) ? EXT_N : sum[W-1:0];
    end

endmodule

// File: rtl/ccd_scan_pos.sv
module ccd_scan_pos #(
    parameter int ROWS = 1024,
    parameter int COLS = 1024,
    parameter int W    = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] row,
    output logic [W-1:0] col,
    output logic         at_vert,
    output logic         at_last
);
    localparam logic [W-1:0] COL_MAX = W'(COLS - 1);
    localparam logic [W-1:0] ROW_MAX = W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row     <= '0;
            col     <= '0;
            at_vert <= 1'b1;
        end else if (step) begin
            if (at_vert) begin
                at_vert <= 1'b0;
                col     <= '0;
            end else if (col == COL_MAX) begin
                at_vert <= 1'b1;
                col     <= '0;
                row     <= (row == ROW_MAX) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign at_last = !at_vert && (col == COL_MAX) && (row == ROW_MAX);

    // R4: column position never leaves the array
    p_col_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col <= COL_MAX);
    // R4: a vertical step is always followed by column zero
    p_vert_then_col0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_vert && !clr) |=> (!at_vert && col == '0));

endmodule

// File: rtl/ccd_table_pick.sv
module ccd_table_pick #(
    parameter int W = 11
) (
    input  logic         at_vert,
    input  logic [W-1:0] row,
    input  logic [W-1:0] col,
    input  logic [W-1:0] row_lo,
    input  logic [W-1:0] row_hi,
    input  logic [W-1:0] col_lo,
    input  logic [W-1:0] col_hi,
    input  logic         hdir,
    input  logic         vdir,
    output logic [2:0]   sel,
    output logic         slow,
    output logic [W-1:0] rel_row,
    output logic [W-1:0] rel_col
);
    import ccd_rd_pkg::*;

    logic row_in, col_in;

    always_comb begin
        row_in  = (row >= row_lo) && (row < row_hi);
        col_in  = (col >= col_lo) && (col < col_hi);
        slow    = !at_vert && row_in && col_in;
        rel_row = row - row_lo;
        rel_col = col - col_lo;
        if (at_vert)   sel = make_sel(CLS_VERT, vdir);
        else if (slow) sel = make_sel(CLS_SLOW, hdir);
        else           sel = make_sel(CLS_FAST, hdir);
    end

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
    parameter int ROWS = 1024,
    parameter int COLS = 1024,
    parameter int W    = $clog2(((ROWS > COLS) ? ROWS : COLS) + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kick,
    input  logic         cancel,
    input  logic [W-1:0] roi_row0,
    input  logic [W-1:0] roi_col0,
    input  logic [W-1:0] roi_nrows,
    input  logic [W-1:0] roi_ncols,
    input  logic         hdir,
    input  logic         vdir,
    output logic         tbl_go,
    output logic [2:0]   tbl_sel,
    input  logic         tbl_fin,
    output logic         busy,
    output logic         pix_stb,
    output logic [W-1:0] pix_row,
    output logic [W-1:0] pix_col,
    output logic         frame_end,
    output logic         frame_cut
);
    import ccd_rd_pkg::*;

    seq_state_t   state, state_nx;
    logic [W-1:0] c_row0, c_col0, c_nrows, c_ncols;
    logic         c_hdir, c_vdir;
    logic         cut_pend;
    logic [W-1:0] row_lo, row_hi, col_lo, col_hi;
    logic [W-1:0] row, col, rel_row, rel_col;
    logic         at_vert, at_last, slow;
    logic         accept, fin_seen;

    assign accept   = (state == S_IDLE) && kick;
    assign fin_seen = (state == S_WAIT) && tbl_fin;

    ccd_win_clip #(.EXTENT(ROWS), .W(W)) i_row_clip (
        .origin(c_row0), .size(c_nrows), .lo(row_lo), .hi(row_hi));
    ccd_win_clip #(.EXTENT(COLS), .W(W)) i_col_clip (
        .origin(c_col0), .size(c_ncols), .lo(col_lo), .hi(col_hi));

    ccd_scan_pos #(.ROWS(ROWS), .COLS(COLS), .W(W)) i_pos (
        .clk(clk), .rst_n(rst_n), .clr(accept), .step(fin_seen),
        .row(row), .col(col), .at_vert(at_vert), .at_last(at_last));

    ccd_table_pick #(.W(W)) i_pick (
        .at_vert(at_vert), .row(row), .col(col),
        .row_lo(row_lo), .row_hi(row_hi), .col_lo(col_lo), .col_hi(col_hi),
        .hdir(c_hdir), .vdir(c_vdir),
        .sel(tbl_sel), .slow(slow), .rel_row(rel_row), .rel_col(rel_col));

    // configuration capture and cancel latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_row0 <= '0; c_col0 <= '0; c_nrows <= '0; c_ncols <= '0;
            c_hdir <= 1'b0; c_vdir <= 1'b0;
            cut_pend <= 1'b0;
        end else begin
            if (accept) begin
                c_row0  <= roi_row0;  c_col0  <= roi_col0;
                c_nrows <= roi_nrows; c_ncols <= roi_ncols;
                c_hdir  <= hdir;      c_vdir  <= vdir;
            end
            if (state == S_END || state == S_IDLE) cut_pend <= 1'b0;
            else if (cancel)                       cut_pend <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (kick) state_nx = S_ISSUE;
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT:  if (tbl_fin)
                         state_nx = (at_last || cut_pend || cancel) ? S_END : S_ISSUE;
            S_END:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tbl_go    = (state == S_ISSUE);
        busy      = (state != S_IDLE);
        frame_end = (state == S_END);
        frame_cut = (state == S_END) && cut_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_stb <= 1'b0;
            pix_row <= '0;
            pix_col <= '0;
        end else begin
            pix_stb <= fin_seen && slow;
            if (fin_seen && slow) begin
                pix_row <= rel_row;
                pix_col <= rel_col;
            end
        end
    end

    // R3: requests are single-cycle pulses
    p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_go |=> !tbl_go);
    // R3: no new request while a table is outstanding
    p_no_go_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !tbl_fin) |=> !tbl_go);
    // R3: table index held while a table runs
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> $stable(tbl_sel));
    // R9: a pixel strobe follows a completion
    p_pix_after_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> $past(tbl_fin));
    // R6: strobed pixels lie inside the clipped window
    p_pix_in_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> (pix_row < row_hi - row_lo) && (pix_col < col_hi - col_lo));
    // R10: frame end returns to idle
    p_end_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !busy);
    // R11: the cut flag only accompanies frame end
    p_cut_with_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cut |-> frame_end);

endmodule

// File: tb/test_ccd_frame_seq.sv
module test_ccd_frame_seq;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int W    = 4;
    localparam int NO_CUT = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic kick = 1'b0, cancel = 1'b0, hdir = 1'b0, vdir = 1'b0, tbl_fin = 1'b0;
    logic [W-1:0] roi_row0 = '0, roi_col0 = '0, roi_nrows = '0, roi_ncols = '0;
    logic tbl_go, busy, pix_stb, frame_end, frame_cut;
    logic [2:0] tbl_sel;
    logic [W-1:0] pix_row, pix_col;

    int total = 0, bad = 0;
    bit finished = 0;
    int e_rlo, e_rhi, e_clo, e_chi, e_hd, e_vd;

    always #5 clk = ~clk;

    ccd_frame_seq #(.ROWS(ROWS), .COLS(COLS), .W(W)) i_ccd_frame_seq (
        .clk(clk), .rst_n(rst_n), .kick(kick), .cancel(cancel),
        .roi_row0(roi_row0), .roi_col0(roi_col0), .roi_nrows(roi_nrows), .roi_ncols(roi_ncols),
        .hdir(hdir), .vdir(vdir), .tbl_go(tbl_go), .tbl_sel(tbl_sel), .tbl_fin(tbl_fin),
        .busy(busy), .pix_stb(pix_stb), .pix_row(pix_row), .pix_col(pix_col),
        .frame_end(frame_end), .frame_cut(frame_cut));

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // expected table class for table number n (R4, R6)
    function automatic bit exp_slow(input int n);
        int r = n / (COLS + 1);
        int k = n % (COLS + 1);
        if (k == 0) return 0;
        return (r >= e_rlo && r < e_rhi && (k-1) >= e_clo && (k-1) < e_chi);
    endfunction

    function automatic int exp_sel(input int n);
        if (n % (COLS + 1) == 0) return e_vd;   // R5 vertical
        if (exp_slow(n))         return 4 + e_hd; // R5 slow
        return 2 + e_hd;                        // R5 fast
    endfunction

    task automatic run_frame(input int ro, input int co, input int rs, input int cs,
                             input int hd, input int vd, input int cut_at, input bit kick_busy);
        int tot = ROWS * (COLS + 1);
        int n = 0;
        bit fin = 0;
        e_rlo = mn(ro, ROWS); e_rhi = mn(ro + rs, ROWS);  // R7
        e_clo = mn(co, COLS); e_chi = mn(co + cs, COLS);
        e_hd = hd; e_vd = vd;
        @(negedge clk);
        roi_row0 = W'(ro); roi_col0 = W'(co); roi_nrows = W'(rs); roi_ncols = W'(cs);
        hdir = hd[0]; vdir = vd[0]; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        // R2: scramble inputs after capture
        roi_row0 = W'(ro + 3); roi_col0 = W'(co + 5); roi_nrows = W'(rs + 1);
        roi_ncols = W'(cs + 2); hdir = ~hdir; vdir = ~vdir;
        while (!fin) begin
            check("R3", "request present", int'(tbl_go), 1);
            if (!tbl_go) begin
                finished = finished; return;
            end
            check("R5", "table select", int'(tbl_sel), exp_sel(n));
            if (n == cut_at) cancel = 1'b1;
            if (kick_busy && n == 3) begin
                kick = 1'b1; roi_row0 = '0; roi_nrows = W'(ROWS); roi_col0 = '0; roi_ncols = W'(COLS);
            end
            @(negedge clk);
            cancel = 1'b0; kick = 1'b0;
            check("R3", "single-cycle request", int'(tbl_go), 0);
            repeat ($urandom % 3) begin
                @(negedge clk);
                check("R3", "no request while waiting", int'(tbl_go), 0);
            end
            tbl_fin = 1'b1;
            @(negedge clk);
            tbl_fin = 1'b0;
            fin = (n == tot - 1) || (n >= cut_at);
            check("R9", "pixel strobe", int'(pix_stb), int'(exp_slow(n)));
            if (exp_slow(n)) begin
                check("R9", "pixel row", int'(pix_row), n / (COLS + 1) - e_rlo);
                check("R9", "pixel col", int'(pix_col), n % (COLS + 1) - 1 - e_clo);
            end
            check("R10", "frame end", int'(frame_end), int'(fin));
            check("R11", "frame cut", int'(frame_cut), int'(fin && n >= cut_at));
            n++;
        end
        check("R4", "table count", n, (cut_at < tot) ? cut_at + 1 : tot);
        @(negedge clk);
        check("R10", "idle after end", int'(busy), 0);
        check("R11", "no request after end", int'(tbl_go), 0);
    endtask

    initial begin
        int unsigned seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R1", "busy at reset", int'(busy), 0);
        check("R1", "request at reset", int'(tbl_go), 0);
        check("R1", "strobe at reset", int'(pix_stb), 0);
        check("R1", "end at reset", int'(frame_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: cancel while idle has no effect
        cancel = 1'b1;
        @(negedge clk);
        cancel = 1'b0;
        @(negedge clk);
        check("R11", "idle cancel busy", int'(busy), 0);
        check("R11", "idle cancel end", int'(frame_end), 0);
        run_frame(0, 0, 8, 8, 0, 0, NO_CUT, 0);   // full window R6
        run_frame(2, 3, 3, 2, 1, 1, NO_CUT, 0);   // interior window
        run_frame(3, 3, 0, 5, 0, 1, NO_CUT, 0);   // R8 zero height
        run_frame(1, 2, 4, 0, 1, 0, NO_CUT, 0);   // R8 zero width
        run_frame(6, 5, 9, 9, 1, 0, NO_CUT, 0);   // R7 clip
        run_frame(12, 0, 3, 3, 0, 0, NO_CUT, 0);  // R7 origin beyond edge
        run_frame(1, 1, 3, 3, 0, 1, NO_CUT, 1);   // R2 kick while busy
        run_frame(0, 0, 4, 4, 1, 1, 20, 0);       // R11 cancel mid-frame
        run_frame(2, 2, 2, 2, 0, 0, 0, 0);        // R11 cancel on first table
        for (int i = 0; i < 6; i++)
            run_frame($urandom % 10, $urandom % 10, $urandom % 10, $urandom % 10,
                      $urandom % 2, $urandom % 2, NO_CUT, 0);
        if (seed == 0) $display("seed zero");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule